// File: doc/BRIEF.md
# Receive Character Queue with Line Status Word

This block sits between a serial receiver and a host register interface. The receiver hands over each finished character with a single-cycle write strobe. The character comes with three error tags: break, framing and parity. The block keeps up to 64 such characters in first-in, first-out order and stores each one with its tags. When a break is reported, the stored byte is forced to 0x00. An overrun pulse from the receiver is also accepted.

The host sees an 8-bit status word at all times and has two read strobes. A strobe on `rd_status` marks that the status word has been consumed, which clears the sticky overrun bit. A strobe on `rd_hold` pops the oldest character into the holding output. The tag bits of the status word come straight from the oldest stored entry, so software reads the status word first and then the character. A separate summary bit stays set while any stored entry carries a tag. Transmitter empty flags are passed through into two status bits.

Top module: `rxq_line_status`

## Requirements
- R1: After a synchronous active-low reset, status bits 0, 1, 2, 3, 4 and 7 are 0, `hold_q` is 0x00 and the queue is empty.
- R2: Status bit 0 is 1 exactly when at least one character is stored.
- R3: Up to 64 characters are stored and are returned on `hold_q` in arrival order. Each value appears one cycle after the `rd_hold` strobe that pops it.
- R4: Status bits 4, 3 and 2 equal the break, framing and parity tags of the oldest stored entry. They are 0 when the queue is empty.
- R5: Status bit 7 is 1 while any stored entry has any tag set, and returns to 0 once the last such entry has been popped.
- R6: A push and a pop in the same cycle keep both the occupancy and the error summary of bit 7 consistent.
- R7: A strobe on `rd_status` never removes or reorders stored characters.
- R8: A write while the queue is full and not being popped is discarded, and it sets status bit 1. A pulse on `rx_overrun` also sets bit 1.
- R9: Status bit 1 clears in the cycle after an `rd_status` strobe, unless a new overrun arrives in that same cycle.
- R10: A character pushed with its break tag set is stored and returned as 0x00, whatever byte accompanied it.
- R11: Status bit 5 equals `tx_hold_empty`. Status bit 6 equals `tx_hold_empty` AND `tx_shift_empty`.
- R12: An `rd_hold` strobe while the queue is empty leaves `hold_q` and the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_wr | input | 1 | Receiver write strobe |
| rx_byte | input | 8 | Received character |
| rx_brk | input | 1 | Break tag of the character |
| rx_frm | input | 1 | Framing error tag |
| rx_par | input | 1 | Parity error tag |
| rx_overrun | input | 1 | Overrun report from the receiver |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rd_status | input | 1 | Host read strobe of the status word |
| rd_hold | input | 1 | Host read strobe of the holding register (pops) |
| status_q | output | 8 | Line status word |
| hold_q | output | 8 | Last popped character |

## Verification
The queue is exercised with three kinds of traffic:
- Clean characters in a short burst test ordering and the data-ready bit.
- A mixed run with one character carrying each tag in turn shows whether the tag bits follow the head entry rather than the newest write or an accumulated value.
- A fill to 64 followed by an extra write separates a correct discard from an overwrite or a pointer wrap.

Same-cycle push and pop of tagged and clean entries distinguishes a correct error count from one that only sets or only clears. Status reads placed between pops show that the status strobe never advances the queue.

// File: rtl/rxq_pkg.sv
// Package: shared types for the receive character queue.
// Assumes an 8-bit character and three per-character tags.
package rxq_pkg;
    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rxq_entry_t;

    function automatic logic entry_has_tag(input rxq_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Module: circular storage for received characters with their tags.
// Accepts a write when not full or when a pop happens in the same cycle.
// Assumes DEPTH is a power of two; the head entry is read combinationally.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  rxq_entry_t       wr_entry,
    input  logic             rd,
    output rxq_entry_t       head,
    output logic             empty,
    output logic             full,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] fill
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Derive empty/full and the accepted push/pop strobes.
    always_comb begin
        empty   = (fill == '0);
        full    = (fill == FULL_CNT);
        pop_ok  = rd && !empty;
        push_ok = wr && (!full || pop_ok);
        head    = mem[rd_ptr];
    end

    // Write accepted entries into storage.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_entry;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_CNT);
    a_r7_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rd_ptr == $past(rd_ptr));
    a_r8_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd) |=> fill == FULL_CNT && wr_ptr == $past(wr_ptr));
endmodule

// File: rtl/rxq_err_tally.sv
// Module: counts stored entries that carry any error tag.
// Assumes push/pop strobes are the accepted ones from the storage.
module rxq_err_tally
    import rxq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_ok,
    input  rxq_entry_t       push_entry,
    input  logic             pop_ok,
    input  rxq_entry_t       pop_entry,
    output logic [CNT_W-1:0] err_cnt,
    output logic             any_err
);
    logic inc, dec;

    // Decide whether this cycle adds or removes a tagged entry.
    always_comb begin
        inc     = push_ok && entry_has_tag(push_entry);
        dec     = pop_ok && entry_has_tag(pop_entry);
        any_err = (err_cnt != '0);
    end

    // Update the tagged-entry count; simultaneous inc and dec cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_cnt <= '0;
        else if (inc && !dec) err_cnt <= err_cnt + 1'b1;
        else if (dec && !inc) err_cnt <= err_cnt - 1'b1;
    end

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !inc |-> err_cnt != '0);
endmodule

// File: rtl/rxq_status_word.sv
// Module: builds the 8-bit line status word and holds the sticky overrun.
// Assumes head tags are valid only when the queue is not empty.
module rxq_status_word
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       empty,
    input  rxq_entry_t head,
    input  logic       any_err,
    input  logic       ovr_set,
    input  logic       rd_status,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    output logic [7:0] word
);
    logic ovr;

    // Sticky overrun: new events win over a clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr <= 1'b0;
        else if (ovr_set)   ovr <= 1'b1;
        else if (rd_status) ovr <= 1'b0;
    end

    // Assemble the word from head tags, summary and transmitter flags.
    always_comb begin
        word[0] = !empty;
        word[1] = ovr;
        word[2] = !empty && head.par;
        word[3] = !empty && head.frm;
        word[4] = !empty && head.brk;
        word[5] = tx_hold_empty;
        word[6] = tx_hold_empty && tx_shift_empty;
        word[7] = any_err;
    end

    a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status && !ovr_set |=> !word[1]);
    a_r8_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> word[1]);
endmodule

// File: rtl/rxq_line_status.sv
// Module: receive queue with line status word (top).
// Wraps storage, error tally and status word; registers the popped byte.
// Assumes host strobes are single-cycle and in this clock domain.
module rxq_line_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_wr,
    input  logic [7:0] rx_byte,
    input  logic       rx_brk,
    input  logic       rx_frm,
    input  logic       rx_par,
    input  logic       rx_overrun,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    input  logic       rd_status,
    input  logic       rd_hold,
    output logic [7:0] status_q,
    output logic [7:0] hold_q
);
    rxq_entry_t       in_entry, head;
    logic             empty, full, push_ok, pop_ok, any_err, ovr_set;
    logic [CNT_W-1:0] fill, err_cnt;

    // Form the entry to store; a break forces a zero byte.
    always_comb begin
        in_entry.brk  = rx_brk;
        in_entry.frm  = rx_frm;
        in_entry.par  = rx_par;
        in_entry.data = rx_brk ? 8'h00 : rx_byte;
        ovr_set       = rx_overrun || (rx_wr && !push_ok);
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr(rx_wr), .wr_entry(in_entry),
        .rd(rd_hold), .head(head), .empty(empty), .full(full),
        .push_ok(push_ok), .pop_ok(pop_ok), .fill(fill)
    );

    rxq_err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .push_entry(in_entry),
        .pop_ok(pop_ok), .pop_entry(head), .err_cnt(err_cnt), .any_err(any_err)
    );

    rxq_status_word u_word (
        .clk(clk), .rst_n(rst_n), .empty(empty), .head(head),
        .any_err(any_err), .ovr_set(ovr_set), .rd_status(rd_status),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .word(status_q)
    );

    // Capture the popped character; empty reads keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 8'h00;
        else if (pop_ok) hold_q <= head.data;
    end

    a_r5_err_le_fill: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= fill);
    a_r4_empty_tags: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> status_q[4:2] == 3'b000 && !status_q[0]);
    a_r11_tx_order: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[6] |-> status_q[5]);
    a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && empty) |=> $stable(hold_q));
    a_r2_full_ready: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> status_q[0]);
endmodule

// File: tb/tb_rxq_line_status.sv
`timescale 1ns/1ps
module tb_rxq_line_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_wr = 0, rx_brk = 0, rx_frm = 0, rx_par = 0, rx_overrun = 0;
    logic [7:0] rx_byte = 0;
    logic       tx_hold_empty = 0, tx_shift_empty = 0;
    logic       rd_status = 0, rd_hold = 0;
    logic [7:0] status_q, hold_q;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    rxq_line_status dut (
        .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_byte(rx_byte),
        .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par),
        .rx_overrun(rx_overrun), .tx_hold_empty(tx_hold_empty),
        .tx_shift_empty(tx_shift_empty), .rd_status(rd_status),
        .rd_hold(rd_hold), .status_q(status_q), .hold_q(hold_q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic b, input logic f, input logic p);
        @(negedge clk);
        rx_wr = 1; rx_byte = d; rx_brk = b; rx_frm = f; rx_par = p;
        @(negedge clk);
        rx_wr = 0; rx_brk = 0; rx_frm = 0; rx_par = 0;
    endtask

    task automatic pop();
        @(negedge clk); rd_hold = 1;
        @(negedge clk); rd_hold = 0;
    endtask

    task automatic read_status();
        @(negedge clk); rd_status = 1;
        @(negedge clk); rd_status = 0;
    endtask

    task automatic t_reset();
        check("R1 status", status_q & 8'h9F, 8'h00);
        check("R1 hold", hold_q, 8'h00);
    endtask

    task automatic t_tx_flags();
        @(negedge clk); tx_hold_empty = 1; tx_shift_empty = 0; #1;
        check("R11 hold only", {6'b0, status_q[6:5]}, 8'h01);
        tx_shift_empty = 1; #1;
        check("R11 both", {6'b0, status_q[6:5]}, 8'h03);
        tx_hold_empty = 0; #1;
        check("R11 shift only", {6'b0, status_q[6:5]}, 8'h00);
        tx_shift_empty = 0;
    endtask

    task automatic t_order();
        push(8'h11, 0, 0, 0); push(8'h22, 0, 0, 0); push(8'h33, 0, 0, 0);
        check("R2 ready", {7'b0, status_q[0]}, 8'h01);
        pop(); check("R3 first", hold_q, 8'h11);
        pop(); check("R3 second", hold_q, 8'h22);
        pop(); check("R3 third", hold_q, 8'h33);
        check("R2 empty", {7'b0, status_q[0]}, 8'h00);
    endtask

    task automatic t_tags();
        push(8'hA1, 0, 0, 0); push(8'hB2, 0, 0, 1);
        push(8'hC3, 0, 1, 0); push(8'h5A, 1, 0, 0);
        check("R4 clean head", {5'b0, status_q[4:2]}, 8'h00);
        check("R5 summary set", {7'b0, status_q[7]}, 8'h01);
        pop(); check("R4 parity head", {5'b0, status_q[4:2]}, 8'h01);
        pop(); check("R4 framing head", {5'b0, status_q[4:2]}, 8'h02);
        pop(); check("R4 break head", {5'b0, status_q[4:2]}, 8'h04);
        check("R5 still set", {7'b0, status_q[7]}, 8'h01);
        pop(); check("R10 break byte", hold_q, 8'h00);
        check("R5 cleared", {7'b0, status_q[7]}, 8'h00);
    endtask

    task automatic t_status_no_pop();
        push(8'h44, 0, 0, 0); push(8'h55, 0, 0, 0);
        read_status(); read_status(); read_status();
        pop(); check("R7 first kept", hold_q, 8'h44);
        pop(); check("R7 second kept", hold_q, 8'h55);
    endtask

    task automatic t_simul();
        push(8'h01, 0, 0, 1); push(8'h02, 0, 0, 0);
        @(negedge clk);
        rd_hold = 1; rx_wr = 1; rx_byte = 8'h03; rx_frm = 1;
        @(negedge clk);
        rd_hold = 0; rx_wr = 0; rx_frm = 0;
        check("R6 popped", hold_q, 8'h01);
        check("R6 summary kept", {7'b0, status_q[7]}, 8'h01);
        pop(); check("R6 clean out", hold_q, 8'h02);
        @(negedge clk);
        rd_hold = 1; rx_wr = 1; rx_byte = 8'h04;
        @(negedge clk);
        rd_hold = 0; rx_wr = 0;
        check("R6 err popped", hold_q, 8'h03);
        check("R6 summary clear", {7'b0, status_q[7]}, 8'h00);
        check("R6 one left", {7'b0, status_q[0]}, 8'h01);
        pop(); check("R6 last", hold_q, 8'h04);
    endtask

    task automatic t_full();
        for (int i = 0; i < 64; i++) push(8'(i + 8'h40), 0, 0, 0);
        check("R8 no ovr yet", {7'b0, status_q[1]}, 8'h00);
        push(8'hFF, 0, 0, 0);
        check("R8 ovr set", {7'b0, status_q[1]}, 8'h01);
        read_status();
        check("R9 ovr cleared", {7'b0, status_q[1]}, 8'h00);
        for (int i = 0; i < 64; i++) begin
            pop();
            check("R3 full order", hold_q, 8'(i + 8'h40));
        end
        check("R8 discarded", {7'b0, status_q[0]}, 8'h00);
        @(negedge clk); rx_overrun = 1;
        @(negedge clk); rx_overrun = 0;
        check("R8 input ovr", {7'b0, status_q[1]}, 8'h01);
        @(negedge clk); rd_status = 1; rx_overrun = 1;
        @(negedge clk); rd_status = 0; rx_overrun = 0;
        check("R9 set wins", {7'b0, status_q[1]}, 8'h01);
        read_status();
        check("R9 cleared again", {7'b0, status_q[1]}, 8'h00);
    endtask

    task automatic t_empty_read();
        pop(); check("R12 hold kept", hold_q, 8'h43 + 8'd60);
        push(8'h99, 0, 0, 0);
        pop(); check("R12 ptr intact", hold_q, 8'h99);
        check("R12 empty", {7'b0, status_q[0]}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_flags();
        t_order();
        t_tags();
        t_status_no_pop();
        t_simul();
        t_full();
        t_empty_read();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule